// File: doc/BRIEF.md
# Two-Way LRU Cache Tag Store

This block is the tag side of a small cache with four sets of two ways each. Each request carries an address. The low-order field above the word offset picks the set, and the bits above that form the tag. One cycle after a request is accepted, the block reports whether the tag was present. It then updates a one-bit recency marker for that set. On a miss it asks the backing memory for the line and installs the tag once the fill arrives.

Stores follow two mode inputs. The first selects write-through or write-back. The second selects whether a store miss allocates a line. When a write-back line that holds modified data is chosen for replacement, the block raises a one-cycle flush pulse that carries the victim's set and tag. Two counters record accepted requests and hits.

Top module: `tagstore_lru2`

## Requirements
- R1: After reset every way is invalid, both counters read zero, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low.
- R2: The set index is `req_addr[LINE_W +: 2]` and the tag is `req_addr[ADDR_W-1 : LINE_W+2]`. The word-offset bits below the set field do not take part in the lookup.
- R3: `rsp_valid` is high exactly in the cycle after each accepted request, and `rsp_hit` then tells whether a valid way of the selected set held the tag.
- R4: A miss fills way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's recency bit. Every hit and every fill makes the touched way the most recent, so that the recency bit names the other way.
- R5: With one-word lines (`LINE_W`=0), the 18-access read trace used by the bench gives exactly 7 hits. That trace is tags 1 2 3 1 4 2 5 6 1 3 4 2 7 3 8 9 1 2 with sets 0 0 2 0 1 0 0 1 0 2 1 0 3 2 3 2 0 0.
- R6: With two-word lines (`LINE_W`=1), the same letter sequence gives exactly 12 hits when it is mapped onto five lines. Three lines share set 0, one line sits in set 1 and one in set 2.
- R7: A miss that needs a fill holds `req_ready` low. The block raises `mem_req_valid` with `mem_req_write`=0 and the request address, then waits for `mem_fill_valid`. It installs the tag on that fill.
- R8: In write-through mode (`wb_mode`=0), every store produces exactly one memory write (`mem_req_write`=1). On an allocating miss this write follows the fill.
- R9: In write-back mode (`wb_mode`=1), a store that hits marks the line dirty and issues no memory write. A store miss that allocates installs the line as dirty. A fill whose victim is valid and dirty pulses `evict_valid` in the cycle after acceptance, with the victim's `evict_set` and `evict_tag`.
- R10: With `alloc_mode`=0, a store miss issues one memory write and does not fill, so that the cache contents and recency are unchanged.
- R11: `access_count` increments once per accepted request, and `hit_count` increments once per hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| wb_mode | input | 1 | 1 for write-back, 0 for write-through |
| alloc_mode | input | 1 | 1 allocates on store miss |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup found the tag |
| evict_valid | output | 1 | Dirty victim must be flushed |
| evict_set | output | 2 | Set of the dirty victim |
| evict_tag | output | TAG_W | Tag of the dirty victim |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a memory write, 0 for a line read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_fill_valid | input | 1 | Line data for the pending read has arrived |
| hit_count | output | CNT_W | Number of hits |
| access_count | output | CNT_W | Number of accepted requests |

## Verification
The bound checker watches several rules on every cycle. A response follows each acceptance by exactly one cycle. Both counters step in line with acceptances and hits, and `hit_count` never passes `access_count`. A flush pulse appears only with a miss response.

Other behaviour only shows over a sequence of requests, so only the bench scenarios can show it. This covers way choice and recency order, the 7- and 12-hit traces, and the number and kind of memory transactions per store under each mode pair. It also covers the dirty victim's identity, and the absence of any fill after a non-allocating store.

// File: rtl/tagstore_lru2.sv
module tagstore_lru2 #(
  parameter int ADDR_W = 8,
  parameter int SET_BITS = 2,
  parameter int LINE_W = 0,
  parameter int CNT_W = 16,
  localparam int TAG_W = ADDR_W - SET_BITS - LINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic                wb_mode,
  input  logic                alloc_mode,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                evict_valid,
  output logic [SET_BITS-1:0] evict_set,
  output logic [TAG_W-1:0]    evict_tag,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_fill_valid,
  output logic [CNT_W-1:0]    hit_count,
  output logic [CNT_W-1:0]    access_count
);
  localparam int SETS = 1 << SET_BITS;

  typedef enum logic [1:0] {IDLE, MEMREQ, FILL} st_t;
  st_t st;

  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic [1:0]       drt_q [SETS];
  logic [SETS-1:0]  lru_q;

  logic [ADDR_W-1:0]   p_addr;
  logic [SET_BITS-1:0] p_set;
  logic [TAG_W-1:0]    p_tag;
  logic p_way, p_wr, p_wb, p_post, m_wr;

  wire [SET_BITS-1:0] set_i = req_addr[LINE_W +: SET_BITS];
  wire [TAG_W-1:0]    tag_i = req_addr[ADDR_W-1 -: TAG_W];
  wire [1:0]          vs    = vld_q[set_i];
  wire hit0   = vs[0] && (tag_q[set_i][0] == tag_i);
  wire hit1   = vs[1] && (tag_q[set_i][1] == tag_i);
  wire hit    = hit0 || hit1;
  wire hway   = hit1;
  wire vic    = !vs[0] ? 1'b0 : (!vs[1] ? 1'b1 : lru_q[set_i]);
  wire accept = req_valid && req_ready;

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == MEMREQ);
  assign mem_req_write = m_wr;
  assign mem_req_addr  = p_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      for (int i = 0; i < SETS; i++) begin
        vld_q[i] <= '0;
        drt_q[i] <= '0;
      end
      lru_q <= '0;
      rsp_valid <= 1'b0;
      rsp_hit <= 1'b0;
      evict_valid <= 1'b0;
      evict_set <= '0;
      evict_tag <= '0;
      hit_count <= '0;
      access_count <= '0;
      p_addr <= '0;
      p_set <= '0;
      p_tag <= '0;
      p_way <= 1'b0;
      p_wr <= 1'b0;
      p_wb <= 1'b0;
      p_post <= 1'b0;
      m_wr <= 1'b0;
    end else begin
      rsp_valid <= accept;
      evict_valid <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          access_count <= access_count + 1'b1;
          rsp_hit <= hit;
          p_addr <= req_addr;
          p_set <= set_i;
          p_tag <= tag_i;
          p_way <= vic;
          p_wr <= req_write;
          p_wb <= wb_mode;
          p_post <= 1'b0;
          if (hit) begin
            hit_count <= hit_count + 1'b1;
            lru_q[set_i] <= ~hway;
            if (req_write) begin
              if (wb_mode) drt_q[set_i][hway] <= 1'b1;
              else begin
                st <= MEMREQ;
                m_wr <= 1'b1;
              end
            end
          end else if (!req_write || alloc_mode) begin
            st <= MEMREQ;
            m_wr <= 1'b0;
            p_post <= req_write && !wb_mode;
            if (vs[vic] && drt_q[set_i][vic]) begin
              evict_valid <= 1'b1;
              evict_set <= set_i;
              evict_tag <= tag_q[set_i][vic];
            end
          end else begin
            st <= MEMREQ;
            m_wr <= 1'b1;
          end
        end
        MEMREQ: if (mem_req_ready) st <= m_wr ? IDLE : FILL;
        FILL: if (mem_fill_valid) begin
          vld_q[p_set][p_way] <= 1'b1;
          drt_q[p_set][p_way] <= p_wr && p_wb;
          lru_q[p_set] <= ~p_way;
          if (p_post) begin
            st <= MEMREQ;
            m_wr <= 1'b1;
            p_post <= 1'b0;
          end else st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == FILL && mem_fill_valid) tag_q[p_set][p_way] <= p_tag;

endmodule

module tagstore_lru2_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             evict_valid,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] access_count
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  // R3
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rsp_valid == $past(req_valid && req_ready));

  // R11
  access_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> access_count == $past(access_count) + CNT_W'($past(req_valid && req_ready)));

  // R11
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> hit_count == $past(hit_count) + CNT_W'(rsp_valid && rsp_hit));

  // R11
  hit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= access_count);

  // R9
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> rsp_valid && !rsp_hit);
endmodule

bind tagstore_lru2 tagstore_lru2_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .evict_valid(evict_valid),
  .hit_count(hit_count), .access_count(access_count)
);

// File: tb/sim_tagstore_lru2.sv
module sim_tagstore_lru2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_write = 0, wb_mode = 0, alloc_mode = 1;
  logic [7:0] req_addr = '0;
  logic mem_req_ready = 0, mem_fill_valid = 0;
  logic req_ready, rsp_valid, rsp_hit, evict_valid, mem_req_valid, mem_req_write;
  logic [1:0] evict_set;
  logic [5:0] evict_tag;
  logic [7:0] mem_req_addr;
  logic [15:0] hit_count, access_count;

  tagstore_lru2 u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .wb_mode(wb_mode),
    .alloc_mode(alloc_mode), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .evict_valid(evict_valid), .evict_set(evict_set), .evict_tag(evict_tag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_fill_valid(mem_fill_valid), .hit_count(hit_count),
    .access_count(access_count));

  logic r1_valid = 0;
  logic [7:0] r1_addr = '0;
  logic r1_ready, r1_rv, r1_rh, r1_ev, r1_mv, r1_mw;
  logic [1:0] r1_es;
  logic [4:0] r1_et;
  logic [7:0] r1_ma;
  logic [15:0] r1_hits, r1_acc;

  tagstore_lru2 #(.LINE_W(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(r1_valid), .req_ready(r1_ready),
    .req_addr(r1_addr), .req_write(1'b0), .wb_mode(1'b0), .alloc_mode(1'b1),
    .rsp_valid(r1_rv), .rsp_hit(r1_rh), .evict_valid(r1_ev), .evict_set(r1_es),
    .evict_tag(r1_et), .mem_req_valid(r1_mv), .mem_req_ready(1'b1),
    .mem_req_write(r1_mw), .mem_req_addr(r1_ma), .mem_fill_valid(1'b1),
    .hit_count(r1_hits), .access_count(r1_acc));

  int checks = 0, errors = 0;
  int exp_hits = 0, exp_acc = 0;

  bit mv [4][2];
  bit md [4][2];
  int mt [4][2];
  bit ml [4];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin
        mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0;
      end
    end
    exp_hits = 0; exp_acc = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic access(input logic [7:0] a, input bit wr, input bit wb, input bit al);
    int s, t, hw, vw, exp_rd, exp_wr, rd, wrn;
    bit hit, ev;
    int ev_tag;
    s = int'(a[1:0]); t = int'(a[7:2]);
    hit = 0; hw = 0; ev = 0; ev_tag = 0; exp_rd = 0; exp_wr = 0;
    for (int w = 0; w < 2; w++)
      if (mv[s][w] && mt[s][w] == t) begin hit = 1; hw = w; end
    exp_acc++;
    if (hit) begin
      exp_hits++;
      ml[s] = (hw == 0);
      if (wr && wb) md[s][hw] = 1;
      exp_wr = (wr && !wb) ? 1 : 0;
    end else if (!wr || al) begin
      vw = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(ml[s]));
      ev = mv[s][vw] && md[s][vw];
      ev_tag = mt[s][vw];
      exp_rd = 1;
      exp_wr = (wr && !wb) ? 1 : 0;
      mv[s][vw] = 1; mt[s][vw] = t; md[s][vw] = wr && wb; ml[s] = (vw == 0);
    end else exp_wr = 1;

    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; wb_mode = wb; alloc_mode = al;
    @(negedge clk);
    req_valid = 0;
    chk("R3 rsp_valid", int'(rsp_valid), 1);
    chk("R4 rsp_hit", int'(rsp_hit), int'(hit));
    chk("R9 evict_valid", int'(evict_valid), int'(ev));
    if (ev) begin
      chk("R9 evict_tag", int'(evict_tag), ev_tag);
      chk("R9 evict_set", int'(evict_set), s);
    end
    if (exp_rd != 0) chk("R7 ready low on miss", int'(req_ready), 0);
    rd = 0; wrn = 0;
    while (!req_ready) begin
      if (mem_req_valid) begin
        bit was_wr;
        was_wr = mem_req_write;
        chk("R7 mem address", int'(mem_req_addr), int'(a));
        repeat ($urandom_range(2, 0)) @(negedge clk);
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        if (was_wr) wrn++;
        else begin
          rd++;
          repeat ($urandom_range(2, 0)) @(negedge clk);
          mem_fill_valid = 1;
          @(negedge clk);
          mem_fill_valid = 0;
        end
      end else @(negedge clk);
    end
    chk("R7 fill reads", rd, exp_rd);
    if (wr && !wb) chk("R8 write-through writes", wrn, exp_wr);
    else if (wr && !al && !hit) chk("R10 no-allocate writes", wrn, exp_wr);
    else chk("R9 memory writes", wrn, exp_wr);
  endtask

  task automatic u1_read(input logic [7:0] a);
    @(negedge clk);
    r1_valid = 1; r1_addr = a;
    @(negedge clk);
    r1_valid = 0;
    while (!r1_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tr_tag [18] = '{1,2,3,1,4,2,5,6,1,3,4,2,7,3,8,9,1,2};
    int tr_set [18] = '{0,0,2,0,1,0,0,1,0,2,1,0,3,2,3,2,0,0};
    int ln_tag [10] = '{0,1,4,2,4,3,3,2,5,5};
    int ln_set [10] = '{0,0,1,0,1,0,0,0,2,2};
    int ln_off [10] = '{0,0,0,0,1,0,1,1,1,0};
    int seed;
    seed = $urandom(32'h5eed);

    do_reset();
    // R1 reset state
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 mem_req_valid", int'(mem_req_valid), 0);
    chk("R1 hit_count", int'(hit_count), 0);
    chk("R1 access_count", int'(access_count), 0);

    // R5 single-word trace, R2 set/tag split, R4 replacement order
    for (int i = 0; i < 18; i++)
      access({tr_tag[i][5:0], tr_set[i][1:0]}, 0, 1, 1);
    chk("R5 trace hits", int'(hit_count), 7);
    chk("R11 access_count", int'(access_count), exp_acc);

    // R6 two-word lines, offsets ignored in lookup
    for (int i = 0; i < 18; i++) begin
      int l;
      l = tr_tag[i];
      u1_read({ln_tag[l][4:0], ln_set[l][1:0], ln_off[l][0]});
    end
    chk("R6 line trace hits", int'(r1_hits), 12);
    chk("R6 line trace accesses", int'(r1_acc), 18);

    do_reset();
    // R9 dirty victim eviction
    access({6'd10, 2'd1}, 1, 1, 1);
    access({6'd11, 2'd1}, 0, 1, 1);
    access({6'd12, 2'd1}, 0, 1, 1);
    // R10 no-allocate store then load misses
    access({6'd20, 2'd2}, 1, 0, 0);
    access({6'd20, 2'd2}, 0, 0, 1);
    // R8 write-through store hit and store miss
    access({6'd20, 2'd2}, 1, 0, 1);
    access({6'd21, 2'd2}, 1, 0, 1);
    // R4 hit refreshes recency
    access({6'd20, 2'd2}, 0, 1, 1);
    access({6'd22, 2'd2}, 0, 1, 1);
    access({6'd20, 2'd2}, 0, 1, 1);
    chk("R11 hit_count", int'(hit_count), exp_hits);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a[7:2] = 6'($urandom_range(3, 0));
      a[1:0] = 2'($urandom_range(3, 0));
      access(a, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
             1'($urandom_range(1, 0)));
    end
    @(negedge clk);
    chk("R11 hit_count", int'(hit_count), exp_hits);
    chk("R11 access_count", int'(access_count), exp_acc);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule